// File: doc/BRIEF.md
# Serial EEPROM Single-Byte Access Controller

This block lets host software read or write one byte of a two-wire serial EEPROM through a single 32-bit command/status word. Software places a memory address, a data byte and a direction flag in the word. Writing the word starts a transfer. The block then drives the clock and data lines through the whole bus exchange: the start condition, the device select byte, the memory address, and then either the data byte or a repeated start followed by a one-byte read. It ends each exchange with a stop condition.

Software polls the busy flag until it clears, then reads the no-acknowledge flag to learn whether a device answered. A read places the received byte in the data field of the same word. The block does not retry a failed transfer. A serial EEPROM often refuses to answer for some milliseconds after a write, so the block ends a refused transfer cleanly and leaves the retry to software. The serial clock comes from the system clock through a divider, and the divide ratio is a parameter.

Top module: `eeprom_byte_ctrl`

## Requirements
- R1: After reset the command/status word reads as all zeros. The word layout is: data in bits 7:0, memory address in bits 15:8, direction in bit 16 (0 = write, 1 = read), no-acknowledge in bit 30, busy in bit 31, and zeros in all other bits.
- R2: A write command produces exactly one start, then the bytes 0xA0, the address and the data, then one stop. When it finishes, busy is 0 and no-acknowledge is 0.
- R3: A read command produces a start, then 0xA0 and the address, then a repeated start and 0xA1. One byte is then clocked in from the device, the master answers it with a not-acknowledge (SDA released), and one stop follows. The received byte then appears in bits 7:0.
- R4: Busy reads 1 from the first cycle after an accepted command write until the stop condition has been sent. It is only ever raised by a command write.
- R5: A command written while busy is 1 changes none of bits 16:0 and does not alter the transfer in progress.
- R6: If no device acknowledges a device select byte (write-select or read-select), the block sends a stop at once, sets no-acknowledge to 1 and clears busy.
- R7: If the memory address byte or the write data byte is not acknowledged, the block sends a stop at once, sets no-acknowledge to 1 and clears busy. After a refused address byte, no further byte is sent.
- R8: A read that ends with no-acknowledge = 1 leaves bits 7:0 holding the data value written with that command.
- R9: While a transfer runs, the rising edges of SCL are exactly CLK_DIV system clocks apart. CLK_DIV must be a multiple of 4 and at least 8.
- R10: An accepted command clears no-acknowledge in the same cycle that busy rises.
- R11: Whenever busy is 0, SCL is released high and SDA is not driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | One-cycle write strobe for the command/status word |
| reg_wr_data | input | 32 | Command word: data, address and direction fields |
| reg_rd_data | output | 32 | Current command/status word |
| scl_o | output | 1 | Serial clock level (1 = released high) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| sda_i | input | 1 | Sampled level of the SDA line |

## Verification
A behavioural EEPROM model on the wires can be told to withhold its acknowledge on the write-select byte, on the address byte, on the data byte or on the read-select byte.

Each of these cases targets a likely fault:
- A controller that ignores one acknowledge slot would carry on clocking bytes or would report success.
- A controller that loses the repeated start would read from the wrong address.
- A controller that acknowledges the read byte would show up as a master acknowledge on the ninth clock.

A command written halfway through a transfer checks that a busy-gated register does not overwrite its fields or redirect the bus. The SCL period is measured on every rising edge, so a divider that is off by one count or stalls between phases is caught.

// File: rtl/eeprom_ctrl_pkg.sv
package eeprom_ctrl_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int ADDR_LSB = 8;
    localparam int DIR_BIT  = 16;
    localparam int NACK_BIT = 30;
    localparam int BUSY_BIT = 31;

    // fixed select address of the serial memory
    localparam logic [6:0] DEV_SEL = 7'b1010000;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_START,
        BUS_TX,
        BUS_ACK,
        BUS_RX,
        BUS_MNACK,
        BUS_STOP
    } bus_state_e;

    typedef enum logic [2:0] {
        SEG_DEVW,
        SEG_ADDR,
        SEG_DATA,
        SEG_DEVR,
        SEG_RDATA
    } seg_e;

    typedef struct packed {
        bus_state_e        st;
        seg_e              seg;
        logic [1:0]        ph;
        logic [2:0]        bitc;
        logic [BYTE_W-1:0] sh;
        logic              ack_bad;
        logic              nack;
        logic              done;
        logic              scl;
        logic              sda;
    } seq_s;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] addr;
        logic              rd;
        logic              busy;
        logic              nack;
    } csr_s;

endpackage

// File: rtl/eeprom_tick_gen.sv
module eeprom_tick_gen #(
    parameter int CLK_DIV = 336
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int QTR = CLK_DIV / 4;
    localparam int CW  = (QTR > 1) ? $clog2(QTR) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (!en_i) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(QTR - 1)) begin
            cnt_d  = '0;
            tick_o = 1'b1;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eeprom_csr.sv
module eeprom_csr
    import eeprom_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              done_i,
    input  logic              nack_i,
    input  logic [BYTE_W-1:0] rx_i,
    output logic              start_o,
    output logic              busy_o,
    output logic              rd_o,
    output logic [BYTE_W-1:0] addr_o,
    output logic [BYTE_W-1:0] data_o,
    output logic [WORD_W-1:0] rd_data_o
);
    csr_s q, d;

    logic unused_bits;
    assign unused_bits = ^wr_data_i[WORD_W-1:DIR_BIT+1];

    always_comb begin
        d       = q;
        start_o = wr_en_i && !q.busy;
        if (start_o) begin
            d.data = wr_data_i[BYTE_W-1:0];
            d.addr = wr_data_i[ADDR_LSB +: BYTE_W];
            d.rd   = wr_data_i[DIR_BIT];
            d.busy = 1'b1;
            d.nack = 1'b0;
        end else if (done_i) begin
            d.busy = 1'b0;
            d.nack = nack_i;
            if (q.rd && !nack_i) d.data = rx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data_o                        = '0;
        rd_data_o[BYTE_W-1:0]            = q.data;
        rd_data_o[ADDR_LSB +: BYTE_W]    = q.addr;
        rd_data_o[DIR_BIT]               = q.rd;
        rd_data_o[NACK_BIT]              = q.nack;
        rd_data_o[BUSY_BIT]              = q.busy;
    end

    assign busy_o = q.busy;
    assign rd_o   = q.rd;
    assign addr_o = q.addr;
    assign data_o = q.data;
endmodule

// File: rtl/eeprom_bus_seq.sv
module eeprom_bus_seq
    import eeprom_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              rd_i,
    input  logic [BYTE_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_oe,
    output logic              done_o,
    output logic              nack_o,
    output logic [BYTE_W-1:0] rx_o
);
    seq_s q, d;

    // returns {scl, sda} for a state, quarter phase and outgoing bit
    function automatic logic [1:0] line_levels(bus_state_e st, logic [1:0] ph, logic b);
        logic mid;
        mid = (ph == 2'd1) || (ph == 2'd2);
        case (st)
            BUS_START: case (ph)
                2'd0:    line_levels = 2'b01;
                2'd1:    line_levels = 2'b11;
                2'd2:    line_levels = 2'b10;
                default: line_levels = 2'b00;
            endcase
            BUS_STOP: case (ph)
                2'd0:    line_levels = 2'b00;
                2'd1:    line_levels = 2'b10;
                default: line_levels = 2'b11;
            endcase
            BUS_TX:                   line_levels = {mid, b};
            BUS_ACK, BUS_RX, BUS_MNACK: line_levels = {mid, 1'b1};
            default:                  line_levels = 2'b11;
        endcase
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.st == BUS_IDLE) begin
            if (start_i) begin
                d.st   = BUS_START;
                d.seg  = SEG_DEVW;
                d.ph   = 2'd0;
                d.sh   = {DEV_SEL, 1'b0};
                d.nack = 1'b0;
            end
        end else if (tick_i) begin
            if (q.ph == 2'd1) begin
                if (q.st == BUS_ACK) d.ack_bad = sda_i;
                if (q.st == BUS_RX)  d.sh      = {q.sh[BYTE_W-2:0], sda_i};
            end
            if (q.ph != 2'd3) begin
                d.ph = q.ph + 2'd1;
            end else begin
                d.ph = 2'd0;
                case (q.st)
                    BUS_START: begin
                        d.st   = BUS_TX;
                        d.bitc = '0;
                    end
                    BUS_TX: begin
                        d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                        if (q.bitc == 3'd7) d.st = BUS_ACK;
                        else                d.bitc = q.bitc + 3'd1;
                    end
                    BUS_ACK: begin
                        d.bitc = '0;
                        if (q.ack_bad) begin
                            d.nack = 1'b1;
                            d.st   = BUS_STOP;
                        end else begin
                            case (q.seg)
                                SEG_DEVW: begin
                                    d.seg = SEG_ADDR;
                                    d.sh  = addr_i;
                                    d.st  = BUS_TX;
                                end
                                SEG_ADDR: begin
                                    if (rd_i) begin
                                        d.seg = SEG_DEVR;
                                        d.sh  = {DEV_SEL, 1'b1};
                                        d.st  = BUS_START;
                                    end else begin
                                        d.seg = SEG_DATA;
                                        d.sh  = data_i;
                                        d.st  = BUS_TX;
                                    end
                                end
                                SEG_DEVR: begin
                                    d.seg = SEG_RDATA;
                                    d.st  = BUS_RX;
                                end
                                default: d.st = BUS_STOP;
                            endcase
                        end
                    end
                    BUS_RX: begin
                        if (q.bitc == 3'd7) d.st = BUS_MNACK;
                        else                d.bitc = q.bitc + 3'd1;
                    end
                    BUS_MNACK: d.st = BUS_STOP;
                    BUS_STOP: begin
                        d.st   = BUS_IDLE;
                        d.done = 1'b1;
                    end
                    default: d.st = BUS_IDLE;
                endcase
            end
        end
        {d.scl, d.sda} = line_levels(d.st, d.ph, d.sh[BYTE_W-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= BUS_IDLE;
            q.seg <= SEG_DEVW;
            q.scl <= 1'b1;
            q.sda <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign scl_o  = q.scl;
    assign sda_oe = !q.sda;
    assign done_o = q.done;
    assign nack_o = q.nack;
    assign rx_o   = q.sh;
endmodule

// File: rtl/eeprom_byte_ctrl.sv
module eeprom_byte_ctrl
    import eeprom_ctrl_pkg::*;
#(
    parameter int CLK_DIV = 336
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        scl_o,
    output logic        sda_oe,
    input  logic        sda_i
);
    logic              cmd_start;
    logic              busy;
    logic              dir_rd;
    logic [BYTE_W-1:0] mem_addr;
    logic [BYTE_W-1:0] wr_byte;
    logic              tick;
    logic              seq_done;
    logic              seq_nack;
    logic [BYTE_W-1:0] rx_byte;

    eeprom_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .wr_data_i (reg_wr_data),
        .done_i    (seq_done),
        .nack_i    (seq_nack),
        .rx_i      (rx_byte),
        .start_o   (cmd_start),
        .busy_o    (busy),
        .rd_o      (dir_rd),
        .addr_o    (mem_addr),
        .data_o    (wr_byte),
        .rd_data_o (reg_rd_data)
    );

    eeprom_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .tick_o (tick)
    );

    eeprom_bus_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cmd_start),
        .tick_i  (tick),
        .rd_i    (dir_rd),
        .addr_i  (mem_addr),
        .data_i  (wr_byte),
        .sda_i   (sda_i),
        .scl_o   (scl_o),
        .sda_oe  (sda_oe),
        .done_o  (seq_done),
        .nack_o  (seq_nack),
        .rx_o    (rx_byte)
    );
endmodule

// File: rtl/eeprom_byte_ctrl_chk.sv
module eeprom_byte_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic        busy,
    input logic        nack,
    input logic [16:0] fields,
    input logic        scl_o,
    input logic        sda_oe,
    input logic        seq_done
);
    // R5
    ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && busy && !seq_done) |=> $stable(fields));

    // R11
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_o && !sda_oe));

    // R10
    nack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !nack);

    // R4
    busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr_en));

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(seq_done));
endmodule

bind eeprom_byte_ctrl eeprom_byte_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .busy      (reg_rd_data[31]),
    .nack      (reg_rd_data[30]),
    .fields    (reg_rd_data[16:0]),
    .scl_o     (scl_o),
    .sda_oe    (sda_oe),
    .seq_done  (seq_done)
);

// File: tb/eeprom_byte_ctrl_test.sv
`timescale 1ns/1ps
module eeprom_byte_ctrl_test;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        scl_o, sda_oe;
    logic        s_drv;
    logic        sda_line;

    always #2.5 clk = ~clk;
    assign sda_line = !(sda_oe || s_drv);

    eeprom_byte_ctrl #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_line)
    );

    int checks = 0, failures = 0;
    bit finished = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural serial memory on the wires
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int         nack_at = 0;
    logic       mon_clr = 1'b0;
    logic       p_scl, p_sda;
    typedef enum int {M_IDLE, M_RX, M_ACK, M_TX, M_MACK} smode_e;
    smode_e     s_mode;
    logic [3:0] s_bit;
    logic [7:0] s_sh, s_tx, s_ptr;
    logic       s_rd;
    int         s_idx, starts, stops, nlog;
    logic [7:0] log_b [8];
    logic       m_acked, mack_seen;
    int         last_rise, scl_bad;

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 37 + 5);
    endfunction

    always @(posedge clk) begin : slave
        logic ok;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            s_mode <= M_IDLE; s_drv <= 0; p_scl <= 1; p_sda <= 1;
            s_bit <= 0; s_idx <= 0; starts <= 0; stops <= 0; nlog <= 0;
            m_acked <= 0; mack_seen <= 0; s_rd <= 0; s_ptr <= 0;
        end else begin
            p_scl <= scl_o; p_sda <= sda_line;
            if (mon_clr) begin
                starts <= 0; stops <= 0; nlog <= 0; m_acked <= 0; mack_seen <= 0;
            end else if (p_scl && scl_o && p_sda && !sda_line) begin
                starts <= starts + 1; s_mode <= M_RX; s_bit <= 0; s_idx <= 0; s_drv <= 0;
            end else if (p_scl && scl_o && !p_sda && sda_line) begin
                stops <= stops + 1; s_mode <= M_IDLE; s_drv <= 0;
            end else if (!p_scl && scl_o) begin
                if (s_mode == M_RX) begin
                    s_sh <= {s_sh[6:0], sda_line}; s_bit <= s_bit + 1;
                end else if (s_mode == M_TX) begin
                    s_bit <= s_bit + 1;
                end else if (s_mode == M_MACK) begin
                    m_acked <= !sda_line; mack_seen <= 1;
                end
            end else if (p_scl && !scl_o) begin
                case (s_mode)
                    M_RX: if (s_bit == 8) begin
                        if (nlog < 8) log_b[nlog] <= s_sh;
                        nlog <= nlog + 1;
                        ok = 1;
                        if (s_idx == 0) begin
                            s_rd <= s_sh[0];
                            ok = (s_sh[7:1] == 7'h50) &&
                                 !((nack_at == 1 && !s_sh[0]) || (nack_at == 4 && s_sh[0]));
                        end else if (s_idx == 1) begin
                            ok = (nack_at != 2);
                            if (ok) s_ptr <= s_sh;
                        end else begin
                            ok = (nack_at != 3);
                            if (ok) mem[s_ptr] <= s_sh;
                        end
                        s_drv  <= ok;
                        s_mode <= ok ? M_ACK : M_IDLE;
                    end
                    M_ACK: begin
                        if (s_idx == 0 && s_rd) begin
                            s_mode <= M_TX; s_tx <= mem[s_ptr]; s_drv <= !mem[s_ptr][7]; s_bit <= 0;
                        end else begin
                            s_mode <= M_RX; s_drv <= 0; s_bit <= 0; s_idx <= s_idx + 1;
                        end
                    end
                    M_TX: if (s_bit == 8) begin
                        s_drv <= 0; s_mode <= M_MACK;
                    end else begin
                        s_drv <= !s_tx[3'(7 - s_bit)];
                    end
                    M_MACK: s_mode <= M_IDLE;
                    default: ;
                endcase
            end
        end
    end

    // SCL period monitor
    always @(posedge clk) begin
        if (!rst_n || mon_clr) begin
            last_rise <= -1;
            if (!rst_n) scl_bad <= 0;
        end else if (!p_scl && scl_o) begin
            if (last_rise >= 0 && (cyc - last_rise) != DIV) scl_bad <= scl_bad + 1;
            last_rise <= cyc;
        end
    end

    task automatic chk(bit cond, string req, string what, int act, int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [31:0] w);
        @(negedge clk); reg_wr_en = 1; reg_wr_data = w;
        @(negedge clk); reg_wr_en = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!reg_rd_data[31]) break;
            @(negedge clk);
        end
    endtask

    task automatic clear_mon(int na);
        @(negedge clk); nack_at = na; mon_clr = 1;
        @(negedge clk); mon_clr = 0;
    endtask

    function automatic int exp_bytes(bit rd, int na);
        if (na == 1) return 1;
        if (na == 2) return 2;
        return 3;
    endfunction

    function automatic bit exp_nack(bit rd, int na);
        if (rd) return (na == 1 || na == 2 || na == 4);
        return (na >= 1 && na <= 3);
    endfunction

    task automatic check_log(bit rd, logic [7:0] a, logic [7:0] dt, int na, string req);
        int nb = exp_bytes(rd, na);
        logic [7:0] e;
        chk(nlog == nb, req, "byte count", nlog, nb);
        for (int i = 0; i < nb && i < nlog; i++) begin
            e = (i == 0) ? 8'hA0 : (i == 1) ? a : (rd ? 8'hA1 : dt);
            chk(log_b[i] == e, req, "bus byte", log_b[i], e);
        end
        chk(stops == 1, req, "stop count", stops, 1);
    endtask

    task automatic do_op(bit rd, logic [7:0] a, logic [7:0] dt, int na);
        bit en;
        int nst;
        clear_mon(na);
        reg_write({1'b0, 1'b1, 13'h1abc, rd, a, dt});
        // R4 R10
        chk(reg_rd_data[31] == 1 && reg_rd_data[30] == 0, "R4/R10", "busy/nack after cmd",
            reg_rd_data[31:30], 2);
        wait_idle();
        repeat (2) @(negedge clk);
        en = exp_nack(rd, na);
        chk(reg_rd_data[31] == 0, "R4", "busy at end", reg_rd_data[31], 0);
        chk(reg_rd_data[30] == en, (na == 0) ? "R2" : (na == 1 || na == 4) ? "R6" : "R7",
            "no-ack flag", reg_rd_data[30], en);
        chk(reg_rd_data[29:17] == 0 && reg_rd_data[16] == rd && reg_rd_data[15:8] == a, "R1",
            "field readback", reg_rd_data[29:8], {13'b0, rd, a});
        chk(scl_o == 1 && sda_oe == 0, "R11", "idle lines", {scl_o, sda_oe}, 2);
        chk(scl_bad == 0, "R9", "scl period errors", scl_bad, 0);
        check_log(rd, a, dt, na, rd ? "R3" : "R2");
        nst = (rd && !(na == 1 || na == 2)) ? 2 : 1;
        chk(starts == nst, "R3", "start count", starts, nst);
        if (rd && !en) begin
            chk(reg_rd_data[7:0] == exp_mem[a], "R3", "read data", reg_rd_data[7:0], exp_mem[a]);
            chk(mack_seen && !m_acked, "R3", "master nack on read byte", m_acked, 0);
        end else if (rd) begin
            chk(reg_rd_data[7:0] == dt, "R8", "data kept on failed read", reg_rd_data[7:0], dt);
        end
        if (!rd && !en) exp_mem[a] = dt;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] snap;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 R11
        chk(reg_rd_data == 0, "R1", "reset word", reg_rd_data, 0);
        chk(scl_o == 1 && sda_oe == 0, "R11", "reset lines", {scl_o, sda_oe}, 2);

        // directed corners
        do_op(0, 8'h00, 8'hFF, 0);
        do_op(1, 8'h00, 8'h11, 0);
        do_op(0, 8'hFF, 8'h00, 0);
        do_op(1, 8'hFF, 8'h22, 0);
        do_op(1, 8'h80, 8'h33, 0);
        for (int na = 1; na <= 4; na++) begin
            do_op(0, 8'h40, 8'h5A, na);
            do_op(1, 8'h40, 8'hC3, na);
            do_op(1, 8'h40, 8'h00, 0); // R10: success after a refused transfer
        end

        // R5: command during busy is ignored
        clear_mon(0);
        reg_write({15'b0, 1'b0, 8'h21, 8'h9E});
        repeat (20) @(negedge clk);
        snap = reg_rd_data;
        reg_write({15'b0, 1'b1, 8'h77, 8'h01});
        chk(reg_rd_data[16:0] == snap[16:0] && reg_rd_data[31], "R5", "fields during busy",
            reg_rd_data[16:0], snap[16:0]);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(reg_rd_data[16:0] == {1'b0, 8'h21, 8'h9E}, "R5", "fields after ignored cmd",
            reg_rd_data[16:0], {1'b0, 8'h21, 8'h9E});
        check_log(0, 8'h21, 8'h9E, 0, "R5");
        exp_mem[8'h21] = 8'h9E;
        do_op(1, 8'h21, 8'h00, 0);

        // constrained random
        for (int k = 0; k < 40; k++) begin
            int r = $urandom % 10;
            do_op(1'($urandom), 8'($urandom), 8'($urandom), (r < 6) ? 0 : r - 5);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule